// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

This block gathers up to 64 interrupt requests and turns them into one core interrupt line plus a 7-bit vector that names the winning source. Most sources are on-chip and are active-low level requests. A group of eight of them comes from external pins. Each external pin is synchronized and then sensed either as an active-low level or as a falling edge. In edge mode an event is held in a pending latch until software clears it.

Two 32-bit mask words enable or block each source. Sources are numbered from the most significant bit downward. A small synchronous register port gives software access to the masks, the edge latches, the sense selection, the routing controls and the vector. External pin 0 can be steered away from the normal interrupt line onto a separate machine-check line, and that line can be turned off.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset, both mask words, the sense word, the pending word and the routing word read 0. The vector reads 0, and `irq_o` and `mc_o` are low.
- R2: Source b (0..31) is enabled by bit 31-b of the high mask word (address 0). Source b (32..63) is enabled by bit 63-b of the low mask word (address 1). A 1 enables the source, and a masked source never raises `irq_o`.
- R3: Internal source b (every b except 0 and 48..55) requests while `int_n[b]` is low. While it is the only enabled request, the vector register (address 5, bits 6:0) reads b.
- R4: When several enabled requests are present, the vector is the lowest requesting source number above 0. Source 0 never requests, and vector 0 means that nothing is requesting.
- R5: `irq_o` goes high in the clock cycle after an enabled request becomes visible to the controller, and it is low whenever no enabled request is routed to it.
- R6: External pin k drives source 48+k through a two-flop synchronizer. In level mode (bit 15-k of the sense word at address 3 is 0) the pin requests while it is low, and `irq_o` rises on the third clock edge after the pin falls.
- R7: In edge mode (bit 15-k of the sense word is 1), a high-to-low change on pin k sets bit 15-k of the pending word (address 2). The latched event stays set after the pin returns high and acts as the source's request. A low-to-high change sets nothing, and in level mode the pending bit never sets.
- R8: Writing the pending word clears each bit written as 1. Bits written as 0 keep their value.
- R9: If a falling edge is detected in the same cycle as a clear of the same pending bit, the bit stays set.
- R10: Routing word (address 4) bit 0 set sends enabled source 48 to `mc_o` and removes it from `irq_o` and the vector. Bit 1 set forces `mc_o` low. `mc_o` is registered.
- R11: A read with `rd_en` high returns the addressed register on `rd_data` after the next clock edge. The mask words read back exactly as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_n | input | 64 | Internal active-low level requests, bit b = source b |
| ext_n | input | 8 | External request pins, bit k = pin k |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Core interrupt request |
| mc_o | output | 1 | Machine-check request |

## Verification
A wrong mask bit or a wrong bit-position mapping shows up within two cycles. Either `irq_o` stays low for an enabled source, or it rises for a blocked one, or the vector names another number. A stuck or lost pending latch appears on the next read of the pending word and in the vector. A synchronizer of the wrong depth moves the rise of `irq_o` by a cycle, and the bench samples that edge exactly. A wrong routing state shows on `mc_o` and `irq_o` in the cycle after the routing write.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SEL_MASK_HI = 3'd0,
        SEL_MASK_LO = 3'd1,
        SEL_PEND    = 3'd2,
        SEL_SENSE   = 3'd3,
        SEL_ROUTE   = 3'd4,
        SEL_VEC     = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/ivc_ext_sense.sv
module ivc_ext_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic active,
    output logic pend
);

    logic meta_q;
    logic sync_q;
    logic prev_q;
    logic fall;

    assign fall = prev_q & ~sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
            pend   <= 1'b0;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
            pend   <= (pend & ~clr) | (fall & edge_mode);
        end
    end

    assign active = edge_mode ? pend : ~sync_q;

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !$past(fall)) |-> !pend);

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fall && edge_mode) |-> pend);

    p_level_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!edge_mode) && !$past(pend)) |-> !pend);

endmodule

// File: rtl/ivc_vec_encoder.sv
module ivc_vec_encoder #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [IDX_W-1:0]   idx,
    output logic               hit
);

    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = NUM_SRC - 1; i >= 1; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import ivc_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_EXT  = 8,
    parameter int EXT_BASE = 48,
    parameter int VEC_W    = 7,
    parameter int ADDR_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        int_n,
    input  logic [7:0]         ext_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    output logic               irq_o,
    output logic               mc_o
);

    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int SENSE_TOP = 15;

    logic [WORD_W-1:0]  mask_hi;
    logic [WORD_W-1:0]  mask_lo;
    logic [NUM_EXT-1:0] sense_edge;
    logic               route_mc;
    logic               mc_off;

    logic [NUM_EXT-1:0] ext_act;
    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_EXT-1:0] pend_clr;

    logic [NUM_SRC-1:0] src_act;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] elig;

    logic [IDX_W-1:0]   win_idx;
    logic               win_hit;
    logic [VEC_W-1:0]   vec;
    logic               mc_req;

    logic [WORD_W-1:0]  pend_word;
    logic [WORD_W-1:0]  sense_word;
    logic [WORD_W-1:0]  rd_mux;
    reg_sel_e           sel;

    logic unused_inputs;
    assign unused_inputs = ^{int_n[0], int_n[EXT_BASE +: NUM_EXT]};

    assign sel = reg_sel_e'(addr);

    // ---------------- external pin sensing ----------------
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        assign pend_clr[k] = wr_en && (sel == SEL_PEND) && wr_data[SENSE_TOP-k];

        ivc_ext_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (sense_edge[k]),
            .clr       (pend_clr[k]),
            .active    (ext_act[k]),
            .pend      (ext_pend[k])
        );
    end

    // ---------------- per-source request, enable, eligibility ----------------
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_src
        if (b < WORD_W) begin : g_hi
            assign src_en[b] = mask_hi[WORD_W-1-b];
        end else begin : g_lo
            assign src_en[b] = mask_lo[2*WORD_W-1-b];
        end

        if (b == 0) begin : g_zero
            assign src_act[b] = 1'b0;
        end else if (b >= EXT_BASE && b < EXT_BASE + NUM_EXT) begin : g_ext_src
            assign src_act[b] = ext_act[b-EXT_BASE];
        end else begin : g_int_src
            assign src_act[b] = ~int_n[b];
        end

        if (b == EXT_BASE) begin : g_routed
            assign elig[b] = src_act[b] & src_en[b] & ~route_mc;
        end else begin : g_plain
            assign elig[b] = src_act[b] & src_en[b];
        end
    end

    assign mc_req = src_act[EXT_BASE] & src_en[EXT_BASE] & route_mc & ~mc_off;

    // ---------------- vector ----------------
    ivc_vec_encoder #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_enc (
        .req (elig),
        .idx (win_idx),
        .hit (win_hit)
    );

    assign vec = win_hit ? VEC_W'(win_idx) : '0;

    // ---------------- register words ----------------
    always_comb begin
        pend_word  = '0;
        sense_word = '0;
        for (int k = 0; k < NUM_EXT; k++) begin
            pend_word[SENSE_TOP-k]  = ext_pend[k];
            sense_word[SENSE_TOP-k] = sense_edge[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_hi    <= '0;
            mask_lo    <= '0;
            sense_edge <= '0;
            route_mc   <= 1'b0;
            mc_off     <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_MASK_HI: mask_hi <= wr_data;
                SEL_MASK_LO: mask_lo <= wr_data;
                SEL_SENSE: begin
                    for (int k = 0; k < NUM_EXT; k++) begin
                        sense_edge[k] <= wr_data[SENSE_TOP-k];
                    end
                end
                SEL_ROUTE: begin
                    route_mc <= wr_data[0];
                    mc_off   <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MASK_HI: rd_mux = mask_hi;
            SEL_MASK_LO: rd_mux = mask_lo;
            SEL_PEND:    rd_mux = pend_word;
            SEL_SENSE:   rd_mux = sense_word;
            SEL_ROUTE:   rd_mux = {30'd0, mc_off, route_mc};
            SEL_VEC:     rd_mux = WORD_W'(vec);
            default:     rd_mux = '0;
        endcase
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            irq_o   <= 1'b0;
            mc_o    <= 1'b0;
        end else begin
            if (rd_en) begin
                rd_data <= rd_mux;
            end
            irq_o <= |elig;
            mc_o  <= mc_req;
        end
    end

    // ---------------- assertions ----------------
    p_vec_is_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '0) |-> elig[win_idx]);

    p_vec_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((elig & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) >> 1) == '0));

    p_vec_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((vec == '0) == (elig == '0)));

    p_mc_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mc_o |-> ($past(route_mc) && !$past(mc_off)));

    p_irq_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (route_mc && (vec != '0)) |-> (win_idx != IDX_W'(EXT_BASE)));

endmodule

// File: tb/test_irq_vector_ctl.sv
module test_irq_vector_ctl;
    import ivc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] int_n = '1;
    logic [7:0]  ext_n = '1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;
    logic        mc_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_vector_ctl i_irq_vector_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_n   (int_n),
        .ext_n   (ext_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o),
        .mc_o    (mc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] mbit(input int b);
        return 32'd1 << (31 - (b % 32));
    endfunction

    function automatic bit is_ext(input int b);
        return (b >= 48) && (b < 56);
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 mc", {31'd0, mc_o}, 32'd0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 32'd0);
        end

        // R11 mask readback
        wr(SEL_MASK_HI, 32'hA5A5_0F0F);
        wr(SEL_MASK_LO, 32'h1234_8001);
        rd(SEL_MASK_HI, d); chk("R11 mask hi", d, 32'hA5A5_0F0F);
        rd(SEL_MASK_LO, d); chk("R11 mask lo", d, 32'h1234_8001);
        wr(SEL_MASK_HI, 32'd0);
        wr(SEL_MASK_LO, 32'd0);
        cyc(2);

        // R2 R3 R5 single-source sweep over every internal source
        for (int b = 1; b < 64; b++) begin
            if (!is_ext(b)) begin
                int_n = '1;
                int_n[b] = 1'b0;
                cyc(2);
                chk("R2 masked source silent", {31'd0, irq_o}, 32'd0);
                wr((b < 32) ? SEL_MASK_HI : SEL_MASK_LO, mbit(b));
                chk("R5 irq not yet", {31'd0, irq_o}, 32'd0);
                cyc(1);
                chk("R5 irq one cycle later", {31'd0, irq_o}, 32'd1);
                rd(SEL_VEC, d);
                chk("R3 vector", d, 32'(b));
                wr((b < 32) ? SEL_MASK_HI : SEL_MASK_LO, 32'd0);
                int_n = '1;
                cyc(1);
                chk("R5 irq drops", {31'd0, irq_o}, 32'd0);
            end
        end

        // R4 priority: all enabled, suffix of internal sources requesting
        wr(SEL_MASK_HI, 32'hFFFF_FFFF);
        wr(SEL_MASK_LO, 32'hFFFF_FFFF);
        for (int lo = 1; lo < 48; lo++) begin
            int_n = '1;
            for (int b = lo; b < 64; b++) if (!is_ext(b)) int_n[b] = 1'b0;
            cyc(1);
            rd(SEL_VEC, d);
            chk("R4 lowest wins", d, 32'(lo));
        end
        int_n = '1;
        int_n[0] = 1'b0;
        cyc(2);
        rd(SEL_VEC, d);
        chk("R4 source 0 never", d, 32'd0);
        chk("R4 irq with source 0 only", {31'd0, irq_o}, 32'd0);
        int_n = '1;

        // R6 external level mode with synchronizer latency
        for (int k = 0; k < 8; k++) begin
            ext_n[k] = 1'b0;
            cyc(2);
            chk("R6 sync delay", {31'd0, irq_o}, 32'd0);
            cyc(1);
            chk("R6 irq after sync", {31'd0, irq_o}, 32'd1);
            rd(SEL_VEC, d);
            chk("R6 vector", d, 32'(48 + k));
            rd(SEL_PEND, d);
            chk("R7 no pend in level mode", d, 32'd0);
            ext_n[k] = 1'b1;
            cyc(4);
            rd(SEL_VEC, d);
            chk("R6 release", d, 32'd0);
        end

        // R7 R8 edge mode
        wr(SEL_SENSE, 32'h0000_FF00);
        rd(SEL_SENSE, d);
        chk("R11 sense readback", d, 32'h0000_FF00);
        for (int k = 0; k < 8; k++) begin
            ext_n[k] = 1'b0;
            cyc(3);
            ext_n[k] = 1'b1;
            cyc(4);
            rd(SEL_PEND, d);
            chk("R7 pend latched", d, 32'd1 << (15 - k));
            rd(SEL_VEC, d);
            chk("R7 vector from pend", d, 32'(48 + k));
            wr(SEL_PEND, ~(32'd1 << (15 - k)));
            rd(SEL_PEND, d);
            chk("R8 zero keeps", d, 32'd1 << (15 - k));
            wr(SEL_PEND, 32'd1 << (15 - k));
            rd(SEL_PEND, d);
            chk("R8 one clears", d, 32'd0);
            cyc(1);
            chk("R8 irq gone", {31'd0, irq_o}, 32'd0);
        end

        // R7 rising edge ignored
        ext_n[5] = 1'b0;
        cyc(5);
        wr(SEL_PEND, 32'd1 << 10);
        ext_n[5] = 1'b1;
        cyc(5);
        rd(SEL_PEND, d);
        chk("R7 rise ignored", d, 32'd0);

        // R9 edge beats simultaneous clear on pin 3
        ext_n[3] = 1'b0;
        cyc(5);
        ext_n[3] = 1'b1;
        cyc(5);
        ext_n[3] = 1'b0;
        cyc(2);
        wr(SEL_PEND, 32'd1 << 12);
        rd(SEL_PEND, d);
        chk("R9 edge wins", d, 32'd1 << 12);
        wr(SEL_PEND, 32'd1 << 12);
        rd(SEL_PEND, d);
        chk("R9 later clear", d, 32'd0);
        ext_n[3] = 1'b1;
        cyc(4);

        // R10 machine-check routing, pin 0 in level mode
        wr(SEL_SENSE, 32'd0);
        wr(SEL_ROUTE, 32'd1);
        ext_n[0] = 1'b0;
        cyc(5);
        chk("R10 mc raised", {31'd0, mc_o}, 32'd1);
        chk("R10 irq excluded", {31'd0, irq_o}, 32'd0);
        rd(SEL_VEC, d);
        chk("R10 vector excluded", d, 32'd0);
        wr(SEL_ROUTE, 32'd3);
        chk("R10 mc still registered", {31'd0, mc_o}, 32'd1);
        cyc(1);
        chk("R10 mc disabled", {31'd0, mc_o}, 32'd0);
        chk("R10 irq still excluded", {31'd0, irq_o}, 32'd0);
        wr(SEL_ROUTE, 32'd0);
        cyc(1);
        chk("R10 back to irq", {31'd0, irq_o}, 32'd1);
        chk("R10 mc low", {31'd0, mc_o}, 32'd0);
        rd(SEL_VEC, d);
        chk("R10 vector 48", d, 32'd48);
        ext_n[0] = 1'b1;
        cyc(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule